// File: doc/BRIEF.md
# PLL Retune Sequencer

This block moves a PLL to a new set of divider values without ever letting a half-programmed or unlocked clock reach its loads. A request gives a reference divider (`nr`), a feedback multiplier (`nf`) and a post divider (`no`), together with a one-cycle start strobe. The values are checked first. The block then bypasses the PLL so that downstream logic runs from the reference oscillator ("slow" mode), holds the PLL in reset, writes the encoded divider and loop-bandwidth fields, and keeps reset asserted for a fixed settle time. After that it releases reset, waits for the lock indication and only then hands the PLL output back to the loads ("normal" mode).

With a reference of `REF_KHZ` the VCO runs at `REF_KHZ*nf/nr` and the output at that rate divided by `no`. A request that would take either of these out of range, or that asks for an odd post divider other than 1, is refused at once and nothing is touched. If lock does not arrive within `LOCK_TIMEOUT` cycles the sequence gives up with an error and leaves the loads on the oscillator. The analog PLL is represented only by its lock input. Working out the divider values is the job of the requester.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset all outputs are 0: mode is slow (`pll_normal`=0), `pll_reset`=0, all four fields 0, `busy`=0, `done`=0, `err`=0.
- R2: A start taken while idle with a legal request sets `busy` and forces slow mode at the next clock edge. `pll_reset` rises one edge later. `pll_normal` is never 1 while `pll_reset` is 1.
- R3: One edge after `pll_reset` rises, the fields take `refdiv_fld`=nr-1, `outdiv_fld`=no-1, `fbdiv_fld`=nf-1 (13 bits) and `bwadj_fld`=floor(nf/2)-1 (12 bits). The fields change at no other time.
- R4: `pll_reset` stays high for SETTLE_US*CLK_PER_US cycles after the fields are written (1251 cycles of high level in total at the defaults), then falls.
- R5: After `pll_reset` falls, the lock input is sampled on every edge. The first edge that sees it high sets `pll_normal`, pulses `done` and clears `busy`.
- R6: A request is legal only if nr≥1, nf≥2, no is 1 or even, 440 MHz ≤ 24 MHz·nf/nr ≤ 2200 MHz, and 27.5 MHz ≤ that rate/no ≤ 2200 MHz. An illegal start pulses `done` and sets `err` at the next edge, and leaves the mode, the reset and the fields unchanged.
- R7: If lock is not seen on any of the LOCK_TIMEOUT edges after reset release, `err` is set, `done` pulses, `busy` clears and the mode stays slow.
- R8: A start that arrives while `busy` is high is ignored. The sequence and the fields it writes are those of the first request.
- R9: `done` is high for exactly one cycle per sequence. `err` keeps its value until the next start that is taken, which sets it again only if that request fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| nr_in | input | 6 | Requested reference divider |
| nf_in | input | 13 | Requested feedback multiplier |
| no_in | input | 4 | Requested post divider |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_reset | output | 1 | PLL reset, high = held in reset |
| pll_normal | output | 1 | Output select: 1 = PLL output, 0 = oscillator bypass |
| refdiv_fld | output | 6 | Reference-divider field |
| fbdiv_fld | output | 13 | Feedback-divider field |
| outdiv_fld | output | 4 | Post-divider field |
| bwadj_fld | output | 12 | Loop-bandwidth field |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last taken request was refused or timed out |

## Verification
The properties assume that `start` is a single-cycle pulse and that the lock input is low while the PLL is held in reset, since a real PLL cannot report lock while it is held there. The stimulus follows both rules. Each request is a one-cycle strobe. The lock is produced by a small PLL stand-in that drops lock as soon as it sees `pll_reset` and raises it a set number of cycles after release, or never, to force the timeout. Request values sit on the exact VCO range edges and on the odd-divider and zero cases, so the legality rule is tested where it changes outcome.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_BYPASS,
    SQ_PROGRAM,
    SQ_SETTLE,
    SQ_LOCKWAIT
  } seq_state_e;

  localparam longint unsigned VCO_LO_KHZ = 64'd440000;
  localparam longint unsigned VCO_HI_KHZ = 64'd2200000;
  localparam longint unsigned OUT_LO_KHZ = 64'd27500;
  localparam longint unsigned OUT_HI_KHZ = 64'd2200000;

  // Range rule evaluated without division: the rates are compared
  // after cross-multiplying by the divisors, so the test is exact.
  function automatic logic divider_set_ok(input longint unsigned ref_khz,
                                          input longint unsigned nr,
                                          input longint unsigned nf,
                                          input longint unsigned no);
    longint unsigned scaled;
    logic vco_ok;
    logic out_ok;
    if (nr == 64'd0 || no == 64'd0 || nf < 64'd2) return 1'b0;
    if (no != 64'd1 && (no % 64'd2) != 64'd0) return 1'b0;
    scaled = ref_khz * nf;
    vco_ok = (scaled >= VCO_LO_KHZ * nr) && (scaled <= VCO_HI_KHZ * nr);
    out_ok = (scaled >= OUT_LO_KHZ * nr * no) && (scaled <= OUT_HI_KHZ * nr * no);
    return vco_ok && out_ok;
  endfunction

  function automatic int unsigned settle_cycles(input int unsigned clk_per_us,
                                                input int unsigned us);
    return clk_per_us * us;
  endfunction

endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check #(
  parameter int REF_KHZ = 24000,
  parameter int NR_W    = 6,
  parameter int NF_W    = 13,
  parameter int NO_W    = 4
) (
  input  logic [NR_W-1:0] nr,
  input  logic [NF_W-1:0] nf,
  input  logic [NO_W-1:0] no,
  output logic            legal
);
  import pll_seq_pkg::*;

  always_comb begin
    legal = divider_set_ok(64'(REF_KHZ), 64'(nr), 64'(nf), 64'(no));
  end

endmodule

// File: rtl/pll_field_enc.sv
module pll_field_enc #(
  parameter int NR_W = 6,
  parameter int NF_W = 13,
  parameter int NO_W = 4
) (
  input  logic [NR_W-1:0] nr,
  input  logic [NF_W-1:0] nf,
  input  logic [NO_W-1:0] no,
  output logic [NR_W-1:0] refdiv,
  output logic [NF_W-1:0] fbdiv,
  output logic [NO_W-1:0] outdiv,
  output logic [NF_W-2:0] bwadj
);
  localparam int BW_W = NF_W - 1;

  always_comb begin
    refdiv = nr - NR_W'(1);
    fbdiv  = nf - NF_W'(1);
    outdiv = no - NO_W'(1);
    bwadj  = nf[NF_W-1:1] - BW_W'(1);
  end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign expired = (remain == '0);

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq #(
  parameter int REF_KHZ      = 24000,
  parameter int CLK_PER_US   = 125,
  parameter int SETTLE_US    = 10,
  parameter int LOCK_TIMEOUT = 2000,
  parameter int NR_W         = 6,
  parameter int NF_W         = 13,
  parameter int NO_W         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NR_W-1:0] nr_in,
  input  logic [NF_W-1:0] nf_in,
  input  logic [NO_W-1:0] no_in,
  input  logic            pll_lock,
  output logic            pll_reset,
  output logic            pll_normal,
  output logic [NR_W-1:0] refdiv_fld,
  output logic [NF_W-1:0] fbdiv_fld,
  output logic [NO_W-1:0] outdiv_fld,
  output logic [NF_W-2:0] bwadj_fld,
  output logic            busy,
  output logic            done,
  output logic            err
);
  import pll_seq_pkg::*;

  localparam int BW_W       = NF_W - 1;
  localparam int SETTLE_CYC = int'(settle_cycles(CLK_PER_US, SETTLE_US));
  localparam int TMR_MAX    = (SETTLE_CYC > LOCK_TIMEOUT) ? SETTLE_CYC : LOCK_TIMEOUT;
  localparam int TMR_W      = $clog2(TMR_MAX + 1);

  seq_state_e state;

  logic [NR_W-1:0] req_nr;
  logic [NF_W-1:0] req_nf;
  logic [NO_W-1:0] req_no;

  // Named internal events
  logic            cfg_legal;
  logic            start_acc;
  logic            fld_wr;
  logic            rst_release;
  logic            lock_seen;
  logic            lock_abort;
  logic            tmr_load;
  logic            tmr_expired;
  logic [TMR_W-1:0] tmr_val;

  logic [NR_W-1:0] enc_refdiv;
  logic [NF_W-1:0] enc_fbdiv;
  logic [NO_W-1:0] enc_outdiv;
  logic [BW_W-1:0] enc_bwadj;

  pll_cfg_check #(
    .REF_KHZ (REF_KHZ),
    .NR_W    (NR_W),
    .NF_W    (NF_W),
    .NO_W    (NO_W)
  ) u_check (
    .nr    (nr_in),
    .nf    (nf_in),
    .no    (no_in),
    .legal (cfg_legal)
  );

  pll_field_enc #(
    .NR_W (NR_W),
    .NF_W (NF_W),
    .NO_W (NO_W)
  ) u_enc (
    .nr     (req_nr),
    .nf     (req_nf),
    .no     (req_no),
    .refdiv (enc_refdiv),
    .fbdiv  (enc_fbdiv),
    .outdiv (enc_outdiv),
    .bwadj  (enc_bwadj)
  );

  assign start_acc   = start && (state == SQ_IDLE);
  assign fld_wr      = (state == SQ_PROGRAM);
  assign rst_release = (state == SQ_SETTLE) && tmr_expired;
  assign lock_seen   = (state == SQ_LOCKWAIT) && pll_lock;
  assign lock_abort  = (state == SQ_LOCKWAIT) && !pll_lock && tmr_expired;
  assign tmr_load    = fld_wr || rst_release;
  assign tmr_val     = fld_wr ? TMR_W'(SETTLE_CYC - 1) : TMR_W'(LOCK_TIMEOUT - 1);

  pll_seq_timer #(
    .CNT_W (TMR_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      req_nr     <= '0;
      req_nf     <= '0;
      req_no     <= '0;
      pll_reset  <= 1'b0;
      pll_normal <= 1'b0;
      refdiv_fld <= '0;
      fbdiv_fld  <= '0;
      outdiv_fld <= '0;
      bwadj_fld  <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (start_acc) begin
            err <= !cfg_legal;
            if (cfg_legal) begin
              req_nr     <= nr_in;
              req_nf     <= nf_in;
              req_no     <= no_in;
              busy       <= 1'b1;
              pll_normal <= 1'b0;
              state      <= SQ_BYPASS;
            end else begin
              done <= 1'b1;
            end
          end
        end
        SQ_BYPASS: begin
          pll_reset <= 1'b1;
          state     <= SQ_PROGRAM;
        end
        SQ_PROGRAM: begin
          refdiv_fld <= enc_refdiv;
          fbdiv_fld  <= enc_fbdiv;
          outdiv_fld <= enc_outdiv;
          bwadj_fld  <= enc_bwadj;
          state      <= SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (rst_release) begin
            pll_reset <= 1'b0;
            state     <= SQ_LOCKWAIT;
          end
        end
        SQ_LOCKWAIT: begin
          if (lock_seen) begin
            pll_normal <= 1'b1;
            done       <= 1'b1;
            busy       <= 1'b0;
            state      <= SQ_IDLE;
          end else if (lock_abort) begin
            err   <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_retune_seq_chk.sv
module pll_retune_seq_chk #(
  parameter int NR_W       = 6,
  parameter int NF_W       = 13,
  parameter int NO_W       = 4,
  parameter int SETTLE_CYC = 1250
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pll_lock,
  input logic            pll_reset,
  input logic            pll_normal,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            fld_wr,
  input logic [NR_W-1:0] refdiv_fld,
  input logic [NF_W-1:0] fbdiv_fld,
  input logic [NO_W-1:0] outdiv_fld,
  input logic [NF_W-2:0] bwadj_fld
);
  logic [31:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (fld_wr) begin
      hold_cnt <= '0;
    end else if (pll_reset) begin
      hold_cnt <= hold_cnt + 32'd1;
    end
  end

  a_r2_slow_during_reset: assert property (@(posedge clk) disable iff (!rst_n)
    pll_reset |-> !pll_normal);

  a_r2_reset_inside_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_reset) |-> $past(busy));

  a_r3_fields_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !fld_wr |=> $stable({refdiv_fld, fbdiv_fld, outdiv_fld, bwadj_fld}));

  a_r4_settle_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_reset) |-> (hold_cnt == 32'(SETTLE_CYC)));

  a_r5_normal_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_normal) |-> ($past(pll_lock) && done));

  a_r6_refusal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(busy)) |-> (err && !pll_reset));

  a_r7_abort_stays_slow: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && err) |-> !pll_normal);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind pll_retune_seq pll_retune_seq_chk #(
  .NR_W       (NR_W),
  .NF_W       (NF_W),
  .NO_W       (NO_W),
  .SETTLE_CYC (CLK_PER_US * SETTLE_US)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pll_lock   (pll_lock),
  .pll_reset  (pll_reset),
  .pll_normal (pll_normal),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .fld_wr     (fld_wr),
  .refdiv_fld (refdiv_fld),
  .fbdiv_fld  (fbdiv_fld),
  .outdiv_fld (outdiv_fld),
  .bwadj_fld  (bwadj_fld)
);

// File: tb/tb_pll_retune_seq.sv
module tb_pll_retune_seq;
  localparam int SETTLE = 1250;
  localparam int TMO    = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  nr_in = '0;
  logic [12:0] nf_in = '0;
  logic [3:0]  no_in = '0;
  logic        pll_lock = 1'b0;
  logic        pll_reset, pll_normal, busy, done, err;
  logic [5:0]  refdiv_fld;
  logic [12:0] fbdiv_fld;
  logic [3:0]  outdiv_fld;
  logic [11:0] bwadj_fld;

  always #4 clk = ~clk;

  pll_retune_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .nr_in(nr_in), .nf_in(nf_in), .no_in(no_in), .pll_lock(pll_lock),
    .pll_reset(pll_reset), .pll_normal(pll_normal),
    .refdiv_fld(refdiv_fld), .fbdiv_fld(fbdiv_fld),
    .outdiv_fld(outdiv_fld), .bwadj_fld(bwadj_fld),
    .busy(busy), .done(done), .err(err)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic cmp(input string tag, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_legal(input int nr, input int nf, input int no);
    real vco, fout;
    if (nr < 1 || nf < 2 || no < 1) return 1'b0;
    if (no != 1 && (no % 2) != 0) return 1'b0;
    vco  = 24.0 * nf / nr;
    fout = vco / no;
    return (vco >= 440.0) && (vco <= 2200.0) && (fout >= 27.5) && (fout <= 2200.0);
  endfunction

  // Behavioural reference: elapsed-time schedule since acceptance
  int m_mode, m_rst, m_ref, m_fb, m_out, m_bw, m_busy, m_done, m_err;
  int m_t, m_wait, q_nr, q_nf, q_no;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_rst = 0; m_ref = 0; m_fb = 0; m_out = 0; m_bw = 0;
      m_busy = 0; m_done = 0; m_err = 0; m_t = 0; m_wait = 0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start) begin
          if (ref_legal(int'(nr_in), int'(nf_in), int'(no_in))) begin
            m_err = 0; m_busy = 1; m_mode = 0; m_t = 0;
            q_nr = int'(nr_in); q_nf = int'(nf_in); q_no = int'(no_in);
          end else begin
            m_err = 1; m_done = 1;
          end
        end
      end else begin
        m_t++;
        if (m_t == 1) m_rst = 1;
        else if (m_t == 2) begin
          m_ref = q_nr - 1; m_fb = q_nf - 1; m_out = q_no - 1; m_bw = q_nf / 2 - 1;
        end else if (m_t == 2 + SETTLE) begin
          m_rst = 0; m_wait = 0;
        end else if (m_t > 2 + SETTLE) begin
          if (pll_lock) begin
            m_mode = 1; m_done = 1; m_busy = 0;
          end else begin
            m_wait++;
            if (m_wait == TMO) begin
              m_err = 1; m_done = 1; m_busy = 0;
            end
          end
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R2/R5", "pll_normal", longint'(pll_normal), longint'(m_mode));
      cmp("R4", "pll_reset", longint'(pll_reset), longint'(m_rst));
      cmp("R3", "refdiv_fld", longint'(refdiv_fld), longint'(m_ref));
      cmp("R3", "fbdiv_fld", longint'(fbdiv_fld), longint'(m_fb));
      cmp("R3", "outdiv_fld", longint'(outdiv_fld), longint'(m_out));
      cmp("R3", "bwadj_fld", longint'(bwadj_fld), longint'(m_bw));
      cmp("R8", "busy", longint'(busy), longint'(m_busy));
      cmp("R9", "done", longint'(done), longint'(m_done));
      cmp("R6/R7", "err", longint'(err), longint'(m_err));
    end
  end

  // PLL stand-in: lock drops in reset, returns lock_delay cycles after release
  int lock_delay = -1;
  int low_cnt = 0;
  bit armed = 1'b0;
  always @(negedge clk) begin
    if (pll_reset) begin
      armed = 1'b1; low_cnt = 0;
    end else if (armed) begin
      low_cnt++;
    end
    pll_lock <= armed && !pll_reset && lock_delay >= 0 && low_cnt >= lock_delay;
  end

  task automatic launch(input int nr, input int nf, input int no);
    @(negedge clk);
    start = 1'b1; nr_in = 6'(nr); nf_in = 13'(nf); no_in = 4'(no);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int rst_cycles);
    rst_cycles = 0;
    while (!done) begin
      if (pll_reset) rst_cycles++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R5 watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    int rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    cmp("R1", "pll_normal", longint'(pll_normal), 0);
    cmp("R1", "pll_reset", longint'(pll_reset), 0);
    cmp("R1", "busy", longint'(busy), 0);
    cmp("R1", "err", longint'(err), 0);
    cmp("R1", "fbdiv_fld", longint'(fbdiv_fld), 0);

    // R3/R5: plain retune
    lock_delay = 5;
    launch(1, 50, 2);
    wait_done(rc);
    cmp("R3", "refdiv", longint'(refdiv_fld), 0);
    cmp("R3", "fbdiv", longint'(fbdiv_fld), 49);
    cmp("R3", "outdiv", longint'(outdiv_fld), 1);
    cmp("R3", "bwadj", longint'(bwadj_fld), 24);
    cmp("R5", "normal", longint'(pll_normal), 1);
    cmp("R9", "done one cycle", longint'(done), 0);

    // R8: second start during a sequence is dropped
    lock_delay = 3;
    launch(9, 400, 2);
    repeat (20) @(negedge clk);
    launch(2, 100, 4);
    wait_done(rc);
    cmp("R8", "fbdiv kept", longint'(fbdiv_fld), 399);
    cmp("R8", "refdiv kept", longint'(refdiv_fld), 8);
    cmp("R8", "bwadj kept", longint'(bwadj_fld), 199);

    // R6: odd post divider refused, nothing touched
    launch(1, 50, 3);
    wait_done(rc);
    cmp("R6", "err odd", longint'(err), 1);
    cmp("R6", "mode untouched", longint'(pll_normal), 1);
    cmp("R6", "fbdiv untouched", longint'(fbdiv_fld), 399);

    // R9: err cleared by next taken start; low VCO edge is legal
    launch(3, 55, 1);
    wait_done(rc);
    cmp("R9", "err cleared", longint'(err), 0);
    cmp("R6", "fbdiv low edge", longint'(fbdiv_fld), 54);
    cmp("R3", "bwadj odd nf", longint'(bwadj_fld), 26);

    // R6: high VCO edge legal, one step above refused
    launch(3, 275, 2);
    wait_done(rc);
    cmp("R6", "err high edge", longint'(err), 0);
    launch(3, 276, 2);
    wait_done(rc);
    cmp("R6", "err above edge", longint'(err), 1);
    launch(1, 1, 1);
    wait_done(rc);
    cmp("R6", "err nf=1", longint'(err), 1);
    launch(0, 50, 2);
    wait_done(rc);
    cmp("R6", "err nr=0", longint'(err), 1);
    launch(1, 100, 2);
    wait_done(rc);
    cmp("R6", "err vco high", longint'(err), 1);
    cmp("R6", "fbdiv after refusals", longint'(fbdiv_fld), 274);

    // R4: reset hold length, immediate lock
    lock_delay = 0;
    launch(1, 75, 1);
    wait_done(rc);
    cmp("R4", "reset high cycles", longint'(rc), longint'(SETTLE + 1));
    cmp("R5", "normal", longint'(pll_normal), 1);

    // R7: lock never arrives
    lock_delay = -1;
    launch(2, 100, 4);
    wait_done(rc);
    cmp("R7", "err timeout", longint'(err), 1);
    cmp("R7", "stays slow", longint'(pll_normal), 0);
    cmp("R7", "reset released", longint'(pll_reset), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule